// File: doc/BRIEF.md
# Return Address Stack with Fault Flags

This block is the hardware return-address stack of a small 8-bit processor core. On a call or on interrupt entry the core pushes the 15-bit program-counter value to return to. On a return instruction it reads the top-of-stack output and pops it. The stack keeps sixteen entries in registers. Processor context is saved in separate shadow registers and never goes onto this stack; only return addresses do.

The stack does not wrap around when it runs out of space or runs dry. A push onto a full stack sets a sticky overflow flag. A pop from an empty stack sets a sticky underflow flag. Each flag holds until software clears it or the power-on reset is applied. When the fault-reset enable input is high, either fault also raises a one-cycle reset request, which the chip's reset controller acts on.

Top module: `ras_stack`

## Requirements
- R1: After reset the stack is empty, `tos_o` is 0, `ovf_o`, `unf_o` and `rst_req_o` are 0.
- R2: A push (push_i=1, pop_i=0) onto a stack of fewer than 16 entries stores `push_addr_i` as the new top. The value appears on `tos_o` in the cycle after the clock edge. Pops return entries in last-in, first-out order, and `tos_o` is 0 whenever the stack is empty.
- R3: A push alone onto a stack that already holds 16 entries sets `ovf_o` in the cycle after the edge. The 16 stored entries and the depth stay unchanged.
- R4: A pop alone from an empty stack sets `unf_o` in the cycle after the edge. The depth stays 0 and `tos_o` stays 0.
- R5: `ovf_o` and `unf_o` stay set until `flag_clr_i` is high at a clock edge, and the clear acts on both flags together. A fault detected at the same edge as the clear leaves its flag set.
- R6: When `fault_rst_en_i` is high at the faulting edge, `rst_req_o` is high for exactly the one cycle after that edge. When it is low, `rst_req_o` stays 0 and the stack behaves exactly as with the enable high.
- R7: A push and a pop in the same cycle on a non-empty stack replace the top entry with `push_addr_i` and leave the depth unchanged. On an empty stack the same pair sets `unf_o` and leaves `push_addr_i` as the only entry.
- R8: Each entry is 15 bits wide and the stack holds 16 entries; all 16 values pushed before the first overflow come back intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| push_i | input | 1 | Push strobe (call or interrupt entry) |
| push_addr_i | input | 15 | Return address to push |
| pop_i | input | 1 | Pop strobe (return instruction) |
| flag_clr_i | input | 1 | Software clear of both fault flags |
| fault_rst_en_i | input | 1 | Allows a fault to raise the reset request |
| tos_o | output | 15 | Current top entry, 0 when empty |
| ovf_o | output | 1 | Sticky overflow flag |
| unf_o | output | 1 | Sticky underflow flag |
| rst_req_o | output | 1 | One-cycle reset request on a fault |

## Verification
The hardest state to reach from the ports is a completely full stack that then takes one more push. Reaching it needs sixteen pushes in a row with distinct values. After the overflow, the test pops all sixteen entries to show that the extra push damaged none of them. The test then pops once more to drive the underflow. It repeats both faults with the reset enable on and off, once at the same edge as a flag clear, and once with a simultaneous push and pop on an empty stack.

// File: rtl/ras_pkg.sv
package ras_pkg;
    typedef enum logic [1:0] {
        OP_IDLE = 2'b00,
        OP_PUSH = 2'b01,
        OP_POP  = 2'b10,
        OP_SWAP = 2'b11
    } ras_op_e;

    typedef struct packed {
        logic ovf;
        logic unf;
        logic req;
    } ras_fault_t;

    function automatic ras_op_e ras_decode(input logic push, input logic pop);
        return ras_op_e'({pop, push});
    endfunction
endpackage

// File: rtl/ras_ptr.sv
module ras_ptr
    import ras_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic          pop_i,
    output logic          wr_en_o,
    output logic [PW-1:0] wr_idx_o,
    output logic [PW-1:0] rd_idx_o,
    output logic          empty_o,
    output logic          ovf_evt_o,
    output logic          unf_evt_o,
    output logic [CW-1:0] cnt_o
);
    typedef struct packed {
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t    st_d, st_q;
    ras_op_e op;
    logic    full, empty;

    always_comb begin
        op        = ras_decode(push_i, pop_i);
        full      = (st_q.cnt == CW'(DEPTH));
        empty     = (st_q.cnt == '0);
        st_d      = st_q;
        wr_en_o   = 1'b0;
        wr_idx_o  = PW'(st_q.cnt);
        ovf_evt_o = 1'b0;
        unf_evt_o = 1'b0;
        unique case (op)
            OP_PUSH: begin
                if (full) begin
                    ovf_evt_o = 1'b1;
                end else begin
                    wr_en_o  = 1'b1;
                    st_d.cnt = st_q.cnt + CW'(1);
                end
            end
            OP_POP: begin
                if (empty) unf_evt_o = 1'b1;
                else       st_d.cnt  = st_q.cnt - CW'(1);
            end
            OP_SWAP: begin
                wr_en_o = 1'b1;
                if (empty) begin
                    unf_evt_o = 1'b1;
                    wr_idx_o  = '0;
                    st_d.cnt  = CW'(1);
                end else begin
                    wr_idx_o = PW'(st_q.cnt - CW'(1));
                end
            end
            default: ;
        endcase
        rd_idx_o = PW'(st_q.cnt - CW'(1));
        empty_o  = empty;
        cnt_o    = st_q.cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/ras_store.sv
module ras_store #(
    parameter int DEPTH = 16,
    parameter int AW    = 15,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en_i,
    input  logic [PW-1:0] wr_idx_i,
    input  logic [AW-1:0] wr_data_i,
    input  logic [PW-1:0] rd_idx_i,
    output logic [AW-1:0] rd_data_o
);
    logic [AW-1:0] mem_d [DEPTH];
    logic [AW-1:0] mem_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        always_comb begin
            mem_d[g] = mem_q[g];
            if (wr_en_i && (wr_idx_i == PW'(g))) mem_d[g] = wr_data_i;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) mem_q[g] <= '0;
            else        mem_q[g] <= mem_d[g];
        end
    end

    assign rd_data_o = mem_q[rd_idx_i];
endmodule

// File: rtl/ras_fault.sv
module ras_fault
    import ras_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ovf_evt_i,
    input  logic unf_evt_i,
    input  logic clr_i,
    input  logic rst_en_i,
    output logic ovf_o,
    output logic unf_o,
    output logic req_o
);
    ras_fault_t f_d, f_q;

    always_comb begin
        f_d     = f_q;
        if (clr_i) begin
            f_d.ovf = 1'b0;
            f_d.unf = 1'b0;
        end
        if (ovf_evt_i) f_d.ovf = 1'b1;
        if (unf_evt_i) f_d.unf = 1'b1;
        f_d.req = rst_en_i & (ovf_evt_i | unf_evt_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign ovf_o = f_q.ovf;
    assign unf_o = f_q.unf;
    assign req_o = f_q.req;
endmodule

// File: rtl/ras_stack.sv
module ras_stack #(
    parameter int DEPTH = 16,
    parameter int AW    = 15,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic [AW-1:0] push_addr_i,
    input  logic          pop_i,
    input  logic          flag_clr_i,
    input  logic          fault_rst_en_i,
    output logic [AW-1:0] tos_o,
    output logic          ovf_o,
    output logic          unf_o,
    output logic          rst_req_o
);
    logic          wr_en, empty, ovf_evt, unf_evt;
    logic [PW-1:0] wr_idx, rd_idx;
    logic [CW-1:0] cnt_w;
    logic [AW-1:0] rd_data;

    ras_ptr #(.DEPTH(DEPTH)) u_ptr (
        .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i),
        .wr_en_o(wr_en), .wr_idx_o(wr_idx), .rd_idx_o(rd_idx),
        .empty_o(empty), .ovf_evt_o(ovf_evt), .unf_evt_o(unf_evt),
        .cnt_o(cnt_w)
    );

    ras_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_idx_i(wr_idx),
        .wr_data_i(push_addr_i), .rd_idx_i(rd_idx), .rd_data_o(rd_data)
    );

    ras_fault u_fault (
        .clk(clk), .rst_n(rst_n), .ovf_evt_i(ovf_evt), .unf_evt_i(unf_evt),
        .clr_i(flag_clr_i), .rst_en_i(fault_rst_en_i),
        .ovf_o(ovf_o), .unf_o(unf_o), .req_o(rst_req_o)
    );

    assign tos_o = empty ? '0 : rd_data;
endmodule

// File: rtl/ras_chk.sv
module ras_chk #(
    parameter int DEPTH = 16,
    parameter int AW    = 15,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          push_i,
    input logic [AW-1:0] push_addr_i,
    input logic          pop_i,
    input logic          flag_clr_i,
    input logic          fault_rst_en_i,
    input logic [AW-1:0] tos_o,
    input logic          ovf_o,
    input logic          unf_o,
    input logic          rst_req_o,
    input logic [CW-1:0] cnt_w
);
    logic full, empty;
    assign full  = (cnt_w == CW'(DEPTH));
    assign empty = (cnt_w == '0);

    assert_push_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && !full) |=> (tos_o == $past(push_addr_i)));

    assert_empty_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> (tos_o == '0));

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && full) |=> (ovf_o && $stable(tos_o) && $stable(cnt_w)));

    assert_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && empty) |=> (unf_o && tos_o == '0));

    assert_ovf_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !flag_clr_i) |=> ovf_o);

    assert_unf_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (unf_o && !flag_clr_i) |=> unf_o);

    assert_req_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |-> ($past(fault_rst_en_i) && (ovf_o || unf_o)));

    assert_swap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i && !empty) |=> (tos_o == $past(push_addr_i) && $stable(cnt_w)));
endmodule

bind ras_stack ras_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .push_i(push_i), .push_addr_i(push_addr_i),
    .pop_i(pop_i), .flag_clr_i(flag_clr_i), .fault_rst_en_i(fault_rst_en_i),
    .tos_o(tos_o), .ovf_o(ovf_o), .unf_o(unf_o), .rst_req_o(rst_req_o),
    .cnt_w(cnt_w)
);

// File: tb/sim_ras_stack.sv
module sim_ras_stack;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 16;
    localparam int AW = 15;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          push_i = 1'b0, pop_i = 1'b0, flag_clr_i = 1'b0, fault_rst_en_i = 1'b0;
    logic [AW-1:0] push_addr_i = '0;
    logic [AW-1:0] tos_o;
    logic          ovf_o, unf_o, rst_req_o;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [AW-1:0] tos;
        logic          ovf, unf, req;
        string         tag;
    } exp_t;

    exp_t exp_q[$];

    logic [AW-1:0] model [DEPTH];
    int            m_cnt = 0;
    logic          m_ovf = 0, m_unf = 0;

    ras_stack u0 (
        .clk(clk), .rst_n(rst_n), .push_i(push_i), .push_addr_i(push_addr_i),
        .pop_i(pop_i), .flag_clr_i(flag_clr_i), .fault_rst_en_i(fault_rst_en_i),
        .tos_o(tos_o), .ovf_o(ovf_o), .unf_o(unf_o), .rst_req_o(rst_req_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check1(input string tag, input string what, input logic [AW-1:0] act,
                          input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic op(input logic ps, input logic pp, input logic [AW-1:0] v,
                      input logic clr, input logic en, input string tag);
        exp_t e;
        logic oe, ue;
        @(negedge clk);
        push_i = ps; pop_i = pp; push_addr_i = v; flag_clr_i = clr; fault_rst_en_i = en;
        @(posedge clk);
        oe = ps && !pp && (m_cnt == DEPTH);
        ue = pp && (m_cnt == 0);
        if (ps && pp) begin
            if (m_cnt == 0) begin model[0] = v; m_cnt = 1; end
            else model[m_cnt-1] = v;
        end else if (ps) begin
            if (m_cnt < DEPTH) begin model[m_cnt] = v; m_cnt++; end
        end else if (pp) begin
            if (m_cnt > 0) m_cnt--;
        end
        if (clr) begin m_ovf = 0; m_unf = 0; end
        if (oe) m_ovf = 1;
        if (ue) m_unf = 1;
        e.tos = (m_cnt == 0) ? '0 : model[m_cnt-1];
        e.ovf = m_ovf; e.unf = m_unf; e.req = en && (oe || ue);
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic idle(input string tag);
        op(0, 0, '0, 0, 0, tag);
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                check1(e.tag, "tos", tos_o, e.tos);
                check1(e.tag, "ovf", AW'(ovf_o), AW'(e.ovf));
                check1(e.tag, "unf", AW'(unf_o), AW'(e.unf));
                check1(e.tag, "req", AW'(rst_req_o), AW'(e.req));
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        repeat (3) @(posedge clk);
        #1;
        check1("R1", "tos", tos_o, '0);
        check1("R1", "ovf", AW'(ovf_o), '0);
        check1("R1", "unf", AW'(unf_o), '0);
        check1("R1", "req", AW'(rst_req_o), '0);
        @(negedge clk);
        rst_n = 1'b1;
        idle("R1");
        // R2: LIFO order
        op(1, 0, 15'h1111, 0, 0, "R2");
        op(1, 0, 15'h7abc, 0, 0, "R2");
        op(1, 0, 15'h0003, 0, 0, "R2");
        op(0, 1, '0, 0, 0, "R2");
        op(0, 1, '0, 0, 0, "R2");
        op(0, 1, '0, 0, 0, "R2");
        // R8: fill all 16 entries with distinct values
        for (int i = 0; i < DEPTH; i++) op(1, 0, AW'(15'h4000 + i * 15'h0123), 0, 0, "R8");
        // R3: overflow with reset request disabled
        op(1, 0, 15'h5555, 0, 0, "R3");
        idle("R3");
        // R6: overflow with reset request enabled, then pulse ends
        op(1, 0, 15'h2222, 0, 1, "R6");
        op(0, 0, '0, 0, 1, "R6");
        // R3/R8: every entry intact after overflow
        for (int i = 0; i < DEPTH; i++) op(0, 1, '0, 0, 0, "R8");
        // R4: underflow
        op(0, 1, '0, 0, 0, "R4");
        idle("R4");
        // R5: clear both flags, then stays clear
        op(0, 0, '0, 1, 0, "R5");
        idle("R5");
        // R6: underflow with enable
        op(0, 1, '0, 0, 1, "R6");
        idle("R6");
        // R5: fault at same edge as clear keeps flag
        op(0, 1, '0, 1, 0, "R5");
        op(0, 0, '0, 1, 0, "R5");
        // R7: push and pop on empty stack
        op(1, 1, 15'h0abc, 0, 0, "R7");
        op(1, 0, 15'h1357, 0, 0, "R7");
        op(1, 1, 15'h2468, 0, 0, "R7");
        op(0, 1, '0, 0, 0, "R7");
        op(0, 1, '0, 0, 0, "R7");
        op(0, 0, '0, 1, 0, "R7");
        repeat (3) @(posedge clk);
        #2;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule